// File: doc/BRIEF.md
# Static Branch Direction Fallback Predictor

This block guesses whether a fetched control-transfer instruction will be taken. When the branch target buffer (BTB) has history for the instruction, the block passes on the BTB's direction one cycle after the lookup. When the BTB misses, the block falls back to fixed rules. These rules use the kind of branch and whether the decoded target lies above or below the branch's own address. The fallback result arrives one cycle later than a BTB result would. Under a mode input, the block can also obey the legacy one-byte direction hint prefixes on conditional branches.

Lookups arrive as a valid/ready stream, and results leave as a plain valid pulse. The result side has no back-pressure, so the consumer must take every `pr_valid` pulse. A lookup is accepted on a rising edge where `lk_valid` and `lk_ready` are both high. The block lowers `lk_ready` for exactly one cycle after it accepts a BTB miss. A lookup offered in that cycle is not taken, and the source must hold or re-offer it. This bubble guarantees that a fallback result and a BTB result never need the output in the same cycle. `pr_taken` and `pr_static` keep their last values in every cycle where `pr_valid` is low.

Top module: `branch_static_fallback`

## Requirements
- R1: A lookup accepted with `lk_btb_hit`=1 gives `pr_valid`=1 in the next cycle, with `pr_taken` equal to `lk_btb_taken` and `pr_static`=0. Hint inputs and the mode input have no effect on it.
- R2: A lookup accepted with `lk_btb_hit`=0 gives `pr_valid`=1 with `pr_static`=1 two cycles later. In the cycle between, `lk_ready`=0 and `pr_valid`=0, and a lookup offered in that cycle is not accepted and yields no result.
- R3: On a miss, a conditional branch (`lk_kind`=2'b00) whose target is above its address, by unsigned comparison, is predicted not taken, unless R7 applies.
- R4: On a miss, a conditional branch whose target is at or below its address is predicted taken. A target equal to the address counts as below. This holds unless R7 applies.
- R5: On a miss, a direct unconditional branch (`lk_kind`=2'b01) is predicted taken, whatever its target.
- R6: On a miss, an indirect branch (`lk_kind`=2'b10) and the unused code 2'b11 are predicted not taken.
- R7: With `hint_mode`=1, `lk_hint_vld`=1 on a conditional miss works as follows. `lk_hint_byte`=8'h3E forces taken and 8'h2E forces not taken, overriding R3/R4. Any other byte value, and any hint on non-conditional kinds, changes nothing.
- R8: With `hint_mode`=0, `lk_hint_vld` and `lk_hint_byte` have no effect on any prediction.
- R9: In a cycle with no result due, `pr_valid`=0 and `pr_taken`/`pr_static` keep their previous values.
- R10: While `rst_n` is low and right after, `pr_valid`, `pr_taken` and `pr_static` are 0 and `lk_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup offered |
| lk_ready | output | 1 | Block can accept a lookup this cycle |
| lk_btb_hit | input | 1 | BTB holds history for this branch |
| lk_btb_taken | input | 1 | BTB's dynamic direction (used on hit) |
| lk_kind | input | 2 | 00 conditional, 01 direct unconditional, 10 indirect, 11 unused |
| lk_pc | input | ADDR_W | Address of the branch instruction |
| lk_target | input | ADDR_W | Decoded target address |
| lk_hint_vld | input | 1 | A hint prefix byte accompanies the instruction |
| lk_hint_byte | input | 8 | Value of that prefix byte |
| hint_mode | input | 1 | 1 = obey legacy hint prefixes, sampled with each lookup |
| pr_valid | output | 1 | A prediction is presented this cycle |
| pr_taken | output | 1 | Predicted direction, 1 = taken |
| pr_static | output | 1 | 1 = fallback rules chose it, 0 = BTB chose it |

## Verification
The bench looks for several wrong corner behaviours:
- A target equal to the branch address must be predicted taken. A design that compares with "strictly below" would predict not taken there.
- Addresses that differ in the top bit catch a design that compares them as signed numbers.
- A BTB hit offered right after a miss checks the one-cycle bubble. A design without it would drop one result or emit two in the same cycle.
- Hint bytes are sent with the mode off, on hits, on non-conditional kinds and as neighbouring byte values. These catch a hint decoder that is too broad, as well as swapped meanings of 0x2E and 0x3E.
- In idle cycles, `pr_taken` and `pr_static` are compared with their last values. This exposes outputs that are cleared instead of held.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

  typedef enum logic [1:0] {
    BK_COND  = 2'b00,
    BK_JUMP  = 2'b01,
    BK_INDIR = 2'b10,
    BK_RSVD  = 2'b11
  } br_kind_e;

  localparam logic [7:0] HINT_TAKE_BYTE = 8'h3E;
  localparam logic [7:0] HINT_SKIP_BYTE = 8'h2E;

  // Everything the second stage needs from a missed lookup.
  typedef struct packed {
    logic     backward;
    br_kind_e kind;
    logic     hint_take;
    logic     hint_skip;
  } miss_info_t;

endpackage

// File: rtl/bsf_dir_cmp.sv
module bsf_dir_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] target,
  output logic              backward
);
  // Unsigned; a branch to itself is treated as a loop.
  assign backward = (target <= pc);
endmodule

// File: rtl/bsf_hint_dec.sv
module bsf_hint_dec
  import bsf_pkg::*;
(
  input  logic       mode,
  input  logic       hint_vld,
  input  logic [7:0] hint_byte,
  output logic       take,
  output logic       skip
);
  logic armed;
  assign armed = mode && hint_vld;
  assign take  = armed && (hint_byte == HINT_TAKE_BYTE);
  assign skip  = armed && (hint_byte == HINT_SKIP_BYTE);
endmodule

// File: rtl/bsf_static_rule.sv
module bsf_static_rule
  import bsf_pkg::*;
(
  input  miss_info_t info,
  output logic       taken
);
  always_comb begin
    unique case (info.kind)
      BK_COND: begin
        if (info.hint_take)      taken = 1'b1;
        else if (info.hint_skip) taken = 1'b0;
        else                     taken = info.backward;
      end
      BK_JUMP: taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/branch_static_fallback.sv
module branch_static_fallback
  import bsf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic              lk_btb_hit,
  input  logic              lk_btb_taken,
  input  logic [1:0]        lk_kind,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic [ADDR_W-1:0] lk_target,
  input  logic              lk_hint_vld,
  input  logic [7:0]        lk_hint_byte,
  input  logic              hint_mode,
  output logic              pr_valid,
  output logic              pr_taken,
  output logic              pr_static
);

  logic       accept, acc_hit, acc_miss;
  logic       miss_busy;
  logic       cmp_back, h_take, h_skip;
  logic       rule_taken;
  miss_info_t s1_d, s1_q;

  assign lk_ready = !miss_busy;
  assign accept   = lk_valid && lk_ready;
  assign acc_hit  = accept && lk_btb_hit;
  assign acc_miss = accept && !lk_btb_hit;

  bsf_dir_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .pc       (lk_pc),
    .target   (lk_target),
    .backward (cmp_back)
  );

  bsf_hint_dec u_hint (
    .mode      (hint_mode),
    .hint_vld  (lk_hint_vld),
    .hint_byte (lk_hint_byte),
    .take      (h_take),
    .skip      (h_skip)
  );

  always_comb begin
    s1_d.backward  = cmp_back;
    s1_d.kind      = br_kind_e'(lk_kind);
    s1_d.hint_take = h_take;
    s1_d.hint_skip = h_skip;
  end

  bsf_static_rule u_rule (
    .info  (s1_q),
    .taken (rule_taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_busy <= 1'b0;
      s1_q      <= '0;
      pr_valid  <= 1'b0;
      pr_taken  <= 1'b0;
      pr_static <= 1'b0;
    end else begin
      miss_busy <= acc_miss;
      if (acc_miss) s1_q <= s1_d;
      pr_valid <= acc_hit || miss_busy;
      if (acc_hit) begin
        pr_taken  <= lk_btb_taken;
        pr_static <= 1'b0;
      end else if (miss_busy) begin
        pr_taken  <= rule_taken;
        pr_static <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bsf_checker.sv
module bsf_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              lk_btb_hit,
  input logic              lk_btb_taken,
  input logic [1:0]        lk_kind,
  input logic [ADDR_W-1:0] lk_pc,
  input logic [ADDR_W-1:0] lk_target,
  input logic              lk_hint_vld,
  input logic [7:0]        lk_hint_byte,
  input logic              hint_mode,
  input logic              pr_valid,
  input logic              pr_taken,
  input logic              pr_static
);
  logic acc, hint_on;
  assign acc     = lk_valid && lk_ready;
  assign hint_on = hint_mode && lk_hint_vld &&
                   (lk_hint_byte == 8'h2E || lk_hint_byte == 8'h3E);

  assert_hit_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && lk_btb_hit |=> pr_valid && !pr_static && (pr_taken == $past(lk_btb_taken)));

  assert_miss_bubble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !lk_btb_hit |=> !lk_ready && !pr_valid);

  assert_miss_late_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !lk_btb_hit |=> ##1 pr_valid && pr_static);

  assert_fwd_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !lk_btb_hit && lk_kind == 2'b00 && lk_target > lk_pc && !hint_on
    |=> ##1 !pr_taken);

  assert_back_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !lk_btb_hit && lk_kind == 2'b00 && lk_target <= lk_pc && !hint_on
    |=> ##1 pr_taken);

  assert_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !lk_btb_hit && lk_kind == 2'b01 |=> ##1 pr_taken);

  assert_indirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !lk_btb_hit && lk_kind[1] |=> ##1 !pr_taken);

  assert_hint_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !lk_btb_hit && lk_kind == 2'b00 && hint_mode && lk_hint_vld &&
    lk_hint_byte == 8'h3E |=> ##1 pr_taken);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_valid |-> $stable(pr_taken) && $stable(pr_static));

endmodule

bind branch_static_fallback bsf_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_btb_hit(lk_btb_hit), .lk_btb_taken(lk_btb_taken), .lk_kind(lk_kind),
  .lk_pc(lk_pc), .lk_target(lk_target), .lk_hint_vld(lk_hint_vld),
  .lk_hint_byte(lk_hint_byte), .hint_mode(hint_mode), .pr_valid(pr_valid),
  .pr_taken(pr_taken), .pr_static(pr_static)
);

// File: tb/sim_branch_static_fallback.sv
`timescale 1ns/1ps
module sim_branch_static_fallback;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0, lk_btb_hit = 1'b0, lk_btb_taken = 1'b0;
  logic [1:0]    lk_kind = 2'b00;
  logic [AW-1:0] lk_pc = '0, lk_target = '0;
  logic          lk_hint_vld = 1'b0, hint_mode = 1'b0;
  logic [7:0]    lk_hint_byte = 8'h00;
  logic          lk_ready, pr_valid, pr_taken, pr_static;

  int checks = 0, errors = 0, cyc = 0;
  bit m_ready = 1'b1, last_tk = 1'b0, last_st = 1'b0;
  int    q_due[$];
  bit    q_tk[$];
  bit    q_st[$];
  string q_req[$];

  always #2 clk = ~clk;

  branch_static_fallback #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_btb_hit(lk_btb_hit), .lk_btb_taken(lk_btb_taken), .lk_kind(lk_kind),
    .lk_pc(lk_pc), .lk_target(lk_target), .lk_hint_vld(lk_hint_vld),
    .lk_hint_byte(lk_hint_byte), .hint_mode(hint_mode), .pr_valid(pr_valid),
    .pr_taken(pr_taken), .pr_static(pr_static)
  );

  task automatic chk(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b exp %0b (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  // Reference rules written from the requirement list.
  function automatic bit ref_dir(logic [1:0] k, logic [AW-1:0] pc, logic [AW-1:0] tg,
                                 bit hv, logic [7:0] hb, bit md, output string req);
    if (k == 2'b00) begin
      if (md && hv && hb == 8'h3E) begin req = "R7"; return 1'b1; end
      if (md && hv && hb == 8'h2E) begin req = "R7"; return 1'b0; end
      req = (hv && !md) ? "R8" : ((tg > pc) ? "R3" : "R4");
      return !(tg > pc);
    end
    if (k == 2'b01) begin req = "R5"; return 1'b1; end
    req = "R6";
    return 1'b0;
  endfunction

  // Inputs are already set; advance one edge and compare at the next negedge.
  task automatic step();
    bit acc, d;
    string r;
    acc = lk_valid && m_ready;
    if (acc) begin
      if (lk_btb_hit) begin
        q_due.push_back(cyc + 1); q_tk.push_back(lk_btb_taken);
        q_st.push_back(1'b0); q_req.push_back("R1");
      end else begin
        d = ref_dir(lk_kind, lk_pc, lk_target, lk_hint_vld, lk_hint_byte, hint_mode, r);
        q_due.push_back(cyc + 2); q_tk.push_back(d);
        q_st.push_back(1'b1); q_req.push_back(r);
      end
    end
    m_ready = !(acc && !lk_btb_hit);
    @(negedge clk);
    cyc++;
    chk("R2", "lk_ready", lk_ready, m_ready);
    if (q_due.size() > 0 && q_due[0] == cyc) begin
      chk(q_req[0], "pr_valid", pr_valid, 1'b1);
      chk(q_req[0], "pr_taken", pr_taken, q_tk[0]);
      chk(q_st[0] ? "R2" : "R1", "pr_static", pr_static, q_st[0]);
      last_tk = q_tk[0]; last_st = q_st[0];
      void'(q_due.pop_front()); void'(q_tk.pop_front());
      void'(q_st.pop_front());  void'(q_req.pop_front());
    end else begin
      chk("R9", "pr_valid", pr_valid, 1'b0);
      chk("R9", "pr_taken hold", pr_taken, last_tk);
      chk("R9", "pr_static hold", pr_static, last_st);
    end
  endtask

  task automatic offer(bit v, bit hit, bit dyn, logic [1:0] k, logic [AW-1:0] pc,
                       logic [AW-1:0] tg, bit hv, logic [7:0] hb, bit md);
    lk_valid = v; lk_btb_hit = hit; lk_btb_taken = dyn; lk_kind = k;
    lk_pc = pc; lk_target = tg; lk_hint_vld = hv; lk_hint_byte = hb; hint_mode = md;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) offer(1'b0, 1'b0, 1'b0, 2'b00, '0, '0, 1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "pr_valid in reset", pr_valid, 1'b0);
    chk("R10", "pr_taken in reset", pr_taken, 1'b0);
    chk("R10", "pr_static in reset", pr_static, 1'b0);
    chk("R10", "lk_ready in reset", lk_ready, 1'b1);
    rst_n = 1'b1;
    idle(2);

    // R1: hits, with hint noise that must not matter
    offer(1, 1, 1, 2'b00, 32'h100, 32'h200, 1, 8'h2E, 1);
    offer(1, 1, 0, 2'b00, 32'h300, 32'h100, 1, 8'h3E, 1);
    idle(2);
    // R3 / R4: forward, backward, equal, top-bit unsigned
    offer(1, 0, 0, 2'b00, 32'h1000, 32'h1040, 0, 8'h00, 0);
    offer(1, 1, 1, 2'b00, 32'h0, 32'h0, 0, 8'h00, 0);       // R2: offered in bubble
    offer(1, 0, 0, 2'b00, 32'h2000, 32'h1F00, 0, 8'h00, 0);
    idle(1);
    offer(1, 0, 0, 2'b00, 32'h3000, 32'h3000, 0, 8'h00, 0); // equal -> backward
    idle(1);
    offer(1, 0, 0, 2'b00, 32'h7FFF_FFF0, 32'h8000_0010, 0, 8'h00, 0);
    idle(1);
    offer(1, 0, 0, 2'b00, 32'h8000_0010, 32'h7FFF_FFF0, 0, 8'h00, 0);
    idle(1);
    // R2: hit straight after a miss's bubble
    offer(1, 0, 0, 2'b01, 32'h500, 32'h400, 0, 8'h00, 0);   // R5
    offer(1, 1, 0, 2'b00, 32'h0, 32'h4, 0, 8'h00, 0);       // refused
    offer(1, 1, 0, 2'b00, 32'h0, 32'h4, 0, 8'h00, 0);       // accepted
    idle(2);
    // R6
    offer(1, 0, 0, 2'b10, 32'h900, 32'h100, 0, 8'h00, 0);
    idle(1);
    offer(1, 0, 0, 2'b11, 32'h900, 32'h100, 1, 8'h3E, 1);
    idle(1);
    // R7: hints override direction; other bytes and kinds ignored
    offer(1, 0, 0, 2'b00, 32'h100, 32'h900, 1, 8'h3E, 1);
    idle(1);
    offer(1, 0, 0, 2'b00, 32'h900, 32'h100, 1, 8'h2E, 1);
    idle(1);
    offer(1, 0, 0, 2'b00, 32'h900, 32'h100, 1, 8'h3F, 1);
    idle(1);
    offer(1, 0, 0, 2'b10, 32'h100, 32'h900, 1, 8'h3E, 1);
    idle(1);
    offer(1, 0, 0, 2'b01, 32'h100, 32'h900, 1, 8'h2E, 1);
    idle(1);
    // R8: mode off
    offer(1, 0, 0, 2'b00, 32'h100, 32'h900, 1, 8'h3E, 0);
    idle(1);
    offer(1, 0, 0, 2'b00, 32'h900, 32'h100, 1, 8'h2E, 0);
    idle(3);

    // Mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] pc;
      logic [AW-1:0] tg;
      logic [7:0] hb;
      int off;
      pc  = $urandom;
      off = int'($urandom_range(0, 8)) - 4;
      tg  = ($urandom_range(0, 3) == 0) ? AW'($urandom) : pc + AW'(off);
      case ($urandom_range(0, 3))
        0: hb = 8'h2E;
        1: hb = 8'h3E;
        2: hb = 8'h3E ^ 8'(1 << $urandom_range(0, 7));
        default: hb = 8'($urandom);
      endcase
      offer(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), pc, tg,
            bit'($urandom_range(0, 1)), hb, bit'($urandom_range(0, 1)));
    end
    idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule